// File: doc/BRIEF.md
# Request/Grant Bus Arbiter with Parking and Response Watchdog

This block decides which of up to sixteen bus masters owns a shared bus. Each master raises a request line and the arbiter answers with a one-hot grant vector. Its ranking comes from an ordered table of master indices. A build-time parameter decides who fills that table. In the fixed scheme software writes it through a small register port. In the adaptive scheme hardware rewrites it after every won request so that the least recently served master ranks highest.

The owner signals an ongoing transfer by driving a shared bus-select input. While that input is high the grant does not move. When nobody requests, a control register parks the bus. It can park on a master named in the register or on the master that owned the bus last. A watchdog counts transfer cycles that see no slave acknowledge and raises a timeout flag after sixteen of them.

A four-state machine carries the ownership. ST_IDLE holds no grant and is the reset state. ST_PARK grants the parking target with no request pending. ST_GRANT grants the winner of a request. ST_BUSY holds the grant while select is high. Every transition is decided at a clock edge. From any state other than ST_IDLE, select high means go to ST_BUSY with the same owner. Otherwise any request means go to ST_GRANT with the winner. Otherwise a valid parking target means go to ST_PARK, and with no valid target the machine goes to ST_IDLE.

Top module: `bus_arbiter`

## Requirements
- R1: The master count is a parameter from 1 to 16. The grant vector is never more than one-hot and changes only at a rising clock edge.
- R2: When the bus is not held, any cycle with at least one request line high is followed, after the next edge, by a grant to one of the masters that requested in that cycle.
- R3: In the fixed scheme, register addresses 0 to N-1 are the ranking slots. Each slot holds a master index in data bits 3:0, and slot 0 ranks highest. The winner is the requesting master found in the lowest slot. Slots are readable at the same addresses.
- R4: A slot holding an index of N or above is skipped. When no master named in a valid slot requests, the lowest-numbered requesting master wins. This covers masters missing from the table because of duplicates.
- R5: In the adaptive scheme, the master that wins a request moves to the last slot and every slot behind its old position moves up by one. Software writes to the slots have no effect there, and the slots read back the current order.
- R6: While the bus is granted and select is high, the grant stays unchanged whatever the request lines do. Re-arbitration happens on the first edge with select low.
- R7: Register address 16 is the control word. Bit 0 picks the parking policy: 0 parks on the master in bits 7:4, and 1 parks on the last owner. With no request and no hold, the grant moves to the parking target. A designated index of N or above leaves no grant.
- R8: The timeout output goes high once ST_BUSY has lasted 16 consecutive cycles with no acknowledge, and it stays high while that holds. An acknowledge clears it after the next edge, and so does leaving ST_BUSY.
- R9: During and after reset the grant and the timeout are low, the control word reads 0, and slot k reads k.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | NUM_MASTERS | One request line per master |
| bus_sel | input | 1 | High while the current owner is in a transfer |
| slave_ack | input | 1 | Slave response strobe |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| gnt | output | NUM_MASTERS | One-hot grant vector |
| timeout | output | 1 | Slave response watchdog flag |

## Verification
The bound checker tests four things on every cycle. The grant is never more than one-hot. A free bus with pending requests is handed to one of those requesters. A held bus keeps its owner. An acknowledge always clears the timeout, and the timeout never follows a cycle that had an acknowledge. The bench scenarios show what those rules cannot. They show which requester wins under several fixed orderings, including duplicated and out-of-range slots, and how the adaptive order evolves across a long request sequence. They also show that slot writes are ignored in adaptive mode, that both parking policies land on the right master, and that the timeout rises on exactly the sixteenth cycle.

// File: rtl/bus_arb_pkg.sv
package bus_arb_pkg;
    localparam int MAX_MASTERS = 16;
    localparam int IDX_W       = 4;
    localparam int ADDR_W      = 5;
    localparam int DATA_W      = 8;
    localparam logic [ADDR_W-1:0] CTRL_ADDR = 5'd16;

    typedef enum logic { PRIO_FIXED = 1'b0, PRIO_LRU = 1'b1 } prio_scheme_e;
    typedef enum logic { PARK_NAMED = 1'b0, PARK_LAST = 1'b1 } park_mode_e;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_PARK  = 2'd1,
        ST_GRANT = 2'd2,
        ST_BUSY  = 2'd3
    } arb_state_e;
endpackage

// File: rtl/bus_arb_regfile.sv
module bus_arb_regfile
    import bus_arb_pkg::*;
#(
    parameter int           NUM_MASTERS = 4,
    parameter prio_scheme_e SCHEME      = PRIO_FIXED
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 reg_we,
    input  logic [ADDR_W-1:0]                    reg_addr,
    input  logic [DATA_W-1:0]                    reg_wdata,
    output logic [DATA_W-1:0]                    reg_rdata,
    input  logic                                 upd_en,
    input  logic [IDX_W-1:0]                     upd_idx,
    output logic [NUM_MASTERS-1:0][IDX_W-1:0]    order,
    output park_mode_e                           park_mode,
    output logic [IDX_W-1:0]                     park_idx
);
    logic [NUM_MASTERS-1:0][IDX_W-1:0] order_q;
    logic unused_wdata;

    assign unused_wdata = ^reg_wdata[3:1];
    assign order        = order_q;

    // control word: parking policy and named parking master
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            park_mode <= PARK_NAMED;
            park_idx  <= '0;
        end else if (reg_we && reg_addr == CTRL_ADDR) begin
            park_mode <= park_mode_e'(reg_wdata[0]);
            park_idx  <= reg_wdata[7:4];
        end
    end

    generate
        if (SCHEME == PRIO_FIXED) begin : g_fixed
            logic unused_upd;
            assign unused_upd = ^{upd_en, upd_idx};

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    for (int s = 0; s < NUM_MASTERS; s++) order_q[s] <= IDX_W'(s);
                end else if (reg_we) begin
                    for (int s = 0; s < NUM_MASTERS; s++)
                        if (reg_addr == ADDR_W'(s)) order_q[s] <= reg_wdata[IDX_W-1:0];
                end
            end
        end else begin : g_lru
            logic [NUM_MASTERS-1:0][IDX_W-1:0] order_nx;
            logic                              seen;

            // winner goes to the tail, the ones behind it close the gap
            always_comb begin
                order_nx = order_q;
                seen     = 1'b0;
                for (int s = 0; s < NUM_MASTERS - 1; s++) begin
                    if (order_q[s] == upd_idx) seen = 1'b1;
                    if (seen) order_nx[s] = order_q[s+1];
                end
                order_nx[NUM_MASTERS-1] = upd_idx;
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    for (int s = 0; s < NUM_MASTERS; s++) order_q[s] <= IDX_W'(s);
                end else if (upd_en) begin
                    order_q <= order_nx;
                end
            end
        end
    endgenerate

    always_comb begin
        reg_rdata = '0;
        if (reg_addr == CTRL_ADDR) reg_rdata = {park_idx, 3'b000, park_mode};
        for (int s = 0; s < NUM_MASTERS; s++)
            if (reg_addr == ADDR_W'(s))
                reg_rdata = {{(DATA_W-IDX_W){1'b0}}, order_q[s]};
    end
endmodule

// File: rtl/bus_arb_pick.sv
module bus_arb_pick
    import bus_arb_pkg::*;
#(
    parameter int NUM_MASTERS = 4
) (
    input  logic [NUM_MASTERS-1:0]               req,
    input  logic [NUM_MASTERS-1:0][IDX_W-1:0]    order,
    output logic                                 any_req,
    output logic [IDX_W-1:0]                     win
);
    localparam logic [IDX_W:0] NM_X = (IDX_W+1)'(NUM_MASTERS);

    logic [MAX_MASTERS-1:0] req_ext;
    logic                   found;

    assign req_ext = MAX_MASTERS'(req);
    assign any_req = |req;

    always_comb begin
        found = 1'b0;
        win   = '0;
        for (int s = 0; s < NUM_MASTERS; s++) begin
            if (!found && ({1'b0, order[s]} < NM_X) && req_ext[order[s]]) begin
                found = 1'b1;
                win   = order[s];
            end
        end
        // fallback for masters absent from the table: lowest index first
        if (!found) begin
            for (int m = NUM_MASTERS - 1; m >= 0; m--)
                if (req[m]) win = IDX_W'(m);
        end
    end
endmodule

// File: rtl/bus_arb_watchdog.sv
module bus_arb_watchdog #(
    parameter int LIMIT = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic busy,
    input  logic ack,
    output logic expired
);
    localparam int CNT_W = $clog2(LIMIT + 1);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(LIMIT);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)               cnt_q <= '0;
        else if (!busy || ack)    cnt_q <= '0;
        else if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
    end

    assign expired = (cnt_q == CNT_MAX);
endmodule

// File: rtl/bus_arbiter.sv
module bus_arbiter
    import bus_arb_pkg::*;
#(
    parameter int           NUM_MASTERS    = 4,
    parameter prio_scheme_e SCHEME         = PRIO_FIXED,
    parameter int           TIMEOUT_CYCLES = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NUM_MASTERS-1:0] req,
    input  logic                   bus_sel,
    input  logic                   slave_ack,
    input  logic                   reg_we,
    input  logic [4:0]             reg_addr,
    input  logic [7:0]             reg_wdata,
    output logic [7:0]             reg_rdata,
    output logic [NUM_MASTERS-1:0] gnt,
    output logic                   timeout
);
    localparam logic [IDX_W:0] NM_X = (IDX_W+1)'(NUM_MASTERS);

    arb_state_e                        state_q, state_d, free_st;
    logic [IDX_W-1:0]                  owner_q, owner_d, free_own;
    logic [NUM_MASTERS-1:0][IDX_W-1:0] order;
    park_mode_e                        park_mode;
    logic [IDX_W-1:0]                  park_idx, park_tgt, win;
    logic                              any_req, park_ok;

    bus_arb_regfile #(.NUM_MASTERS(NUM_MASTERS), .SCHEME(SCHEME)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .upd_en(state_d == ST_GRANT), .upd_idx(owner_d),
        .order(order), .park_mode(park_mode), .park_idx(park_idx)
    );

    bus_arb_pick #(.NUM_MASTERS(NUM_MASTERS)) u_pick (
        .req(req), .order(order), .any_req(any_req), .win(win)
    );

    bus_arb_watchdog #(.LIMIT(TIMEOUT_CYCLES)) u_wdog (
        .clk(clk), .rst_n(rst_n), .busy(state_q == ST_BUSY), .ack(slave_ack), .expired(timeout)
    );

    // owner_q doubles as the last owner, it is kept through ST_IDLE
    assign park_tgt = (park_mode == PARK_LAST) ? owner_q : park_idx;
    assign park_ok  = ({1'b0, park_tgt} < NM_X);

    // destination when the bus is free
    always_comb begin
        if (any_req) begin
            free_st  = ST_GRANT;
            free_own = win;
        end else if (park_ok) begin
            free_st  = ST_PARK;
            free_own = park_tgt;
        end else begin
            free_st  = ST_IDLE;
            free_own = owner_q;
        end
    end

    always_comb begin
        state_d = free_st;
        owner_d = free_own;
        unique case (state_q)
            ST_IDLE: ;
            ST_PARK, ST_GRANT, ST_BUSY: begin
                if (bus_sel) begin
                    state_d = ST_BUSY;
                    owner_d = owner_q;
                end
            end
            default: ;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            owner_q <= '0;
        end else begin
            state_q <= state_d;
            owner_q <= owner_d;
        end
    end

    // outputs
    always_comb begin
        for (int m = 0; m < NUM_MASTERS; m++)
            gnt[m] = (state_q != ST_IDLE) && (owner_q == IDX_W'(m));
    end
endmodule

// File: rtl/bus_arbiter_chk.sv
module bus_arbiter_chk #(
    parameter int NUM_MASTERS = 4
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic [NUM_MASTERS-1:0] req,
    input logic                   bus_sel,
    input logic                   slave_ack,
    input logic [NUM_MASTERS-1:0] gnt,
    input logic                   timeout
);
    a_r1_onehot_grant: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt));

    a_r2_request_served: assert property (@(posedge clk) disable iff (!rst_n)
        (|req && !(bus_sel && |gnt)) |=> |(gnt & $past(req)));

    a_r6_hold_owner: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && |gnt) |=> gnt == $past(gnt));

    a_r8_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
        slave_ack |=> !timeout);

    a_r8_timeout_no_prior_ack: assert property (@(posedge clk) disable iff (!rst_n)
        timeout |-> $past(!slave_ack));
endmodule

bind bus_arbiter bus_arbiter_chk #(.NUM_MASTERS(NUM_MASTERS)) u_chk (
    .clk(clk), .rst_n(rst_n), .req(req), .bus_sel(bus_sel),
    .slave_ack(slave_ack), .gnt(gnt), .timeout(timeout)
);

// File: tb/tb_bus_arbiter.sv
`timescale 1ns/1ps
module tb_bus_arbiter;
    import bus_arb_pkg::*;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] req = '0;
    logic       bus_sel = 1'b0, slave_ack = 1'b0, reg_we = 1'b0;
    logic [4:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] rdata_f, rdata_l;
    logic [3:0] gnt_f, gnt_l;
    logic       to_f, to_l;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    int fo[4];
    int lm[4];

    always #2.5 clk = ~clk;

    bus_arbiter #(.NUM_MASTERS(4), .SCHEME(PRIO_FIXED)) dut (
        .clk(clk), .rst_n(rst_n), .req(req), .bus_sel(bus_sel), .slave_ack(slave_ack),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(rdata_f),
        .gnt(gnt_f), .timeout(to_f)
    );

    bus_arbiter #(.NUM_MASTERS(4), .SCHEME(PRIO_LRU)) dut_lru (
        .clk(clk), .rst_n(rst_n), .req(req), .bus_sel(bus_sel), .slave_ack(slave_ack),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(rdata_l),
        .gnt(gnt_l), .timeout(to_l)
    );

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int exp_fixed(logic [3:0] r);
        for (int s = 0; s < 4; s++)
            if (fo[s] < 4 && r[fo[s]]) return fo[s];
        for (int m = 0; m < 4; m++)
            if (r[m]) return m;
        return 0;
    endfunction

    function automatic int lru_pick(logic [3:0] r);
        for (int s = 0; s < 4; s++)
            if (r[lm[s]]) return lm[s];
        return 0;
    endfunction

    task automatic lru_move(int w);
        int p = 0;
        for (int s = 0; s < 4; s++) if (lm[s] == w) p = s;
        for (int s = p; s < 3; s++) lm[s] = lm[s+1];
        lm[3] = w;
    endtask

    task automatic wr(logic [4:0] a, logic [7:0] d);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        tick();
        reg_we = 1'b0;
    endtask

    task automatic set_order(int a, int b, int c, int d);
        req = '0;
        fo[0] = a; fo[1] = b; fo[2] = c; fo[3] = d;
        for (int s = 0; s < 4; s++) wr(5'(s), 8'(fo[s]));
        for (int s = 0; s < 4; s++) begin
            reg_addr = 5'(s);
            #1;
            chk("R3 slot readback", 32'(rdata_f), 32'(fo[s]));
            chk("R5 slot write ignored", 32'(rdata_l), 32'(lm[s]));
        end
    endtask

    task automatic step(string tag, logic [3:0] r);
        int w;
        req = r;
        tick();
        chk(tag, 32'(gnt_f), 32'(1) << exp_fixed(r));
        w = lru_pick(r);
        chk("R5 adaptive winner", 32'(gnt_l), 32'(1) << w);
        lru_move(w);
    endtask

    task automatic sweep(string tag);
        for (int r = 1; r < 16; r++) step(tag, 4'(r));
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc == 20000) begin
            fails++;
            $display("FAIL R1 watchdog: cycles=%0d expected < %0d", cyc, 20000);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        for (int s = 0; s < 4; s++) begin fo[s] = s; lm[s] = s; end
        repeat (3) tick();
        // R9: reset values
        chk("R9 grant in reset", 32'(gnt_f), 32'h0);
        chk("R9 adaptive grant in reset", 32'(gnt_l), 32'h0);
        chk("R9 timeout in reset", 32'(to_f), 32'h0);
        rst_n = 1'b1;
        for (int s = 0; s < 4; s++) begin
            reg_addr = 5'(s);
            #1;
            chk("R9 slot identity", 32'(rdata_f), 32'(s));
            chk("R9 adaptive slot identity", 32'(rdata_l), 32'(s));
        end
        reg_addr = CTRL_ADDR;
        #1;
        chk("R9 control word", 32'(rdata_f), 32'h0);
        tick();
        chk("R7 default park on master 0", 32'(gnt_f), 32'h1);

        // R3 / R4: several orderings, every request pattern
        set_order(0, 1, 2, 3);  sweep("R3 identity order");
        set_order(3, 2, 1, 0);  sweep("R3 reverse order");
        set_order(2, 0, 3, 1);  sweep("R3 mixed order");
        set_order(2, 2, 2, 2);  sweep("R4 duplicate slots");
        set_order(9, 1, 15, 3); sweep("R4 out-of-range slots");

        // R6 / R8: hold and response watchdog
        set_order(0, 1, 2, 3);
        step("R2 single request", 4'b0001);
        bus_sel = 1'b1;
        req = 4'b1110;
        tick();
        chk("R6 hold first cycle", 32'(gnt_f), 32'h1);
        for (int k = 1; k < 16; k++) begin
            tick();
            chk("R6 grant held", 32'(gnt_f), 32'h1);
            chk("R6 adaptive grant held", 32'(gnt_l), 32'h1);
        end
        chk("R8 no timeout after 15", 32'(to_f), 32'h0);
        tick();
        chk("R8 timeout after 16", 32'(to_f), 32'h1);
        chk("R8 adaptive timeout after 16", 32'(to_l), 32'h1);
        tick();
        chk("R8 timeout stays", 32'(to_f), 32'h1);
        slave_ack = 1'b1;
        tick();
        slave_ack = 1'b0;
        chk("R8 ack clears", 32'(to_f), 32'h0);
        repeat (10) tick();
        chk("R8 restarted count", 32'(to_f), 32'h0);
        bus_sel = 1'b0;
        step("R6 re-arbitrate on release", 4'b1110);
        chk("R8 no timeout after release", 32'(to_f), 32'h0);

        // R7: parking policies
        req = '0;
        wr(CTRL_ADDR, 8'h20);
        tick();
        chk("R7 park on named master", 32'(gnt_f), 32'h4);
        chk("R7 adaptive park on named master", 32'(gnt_l), 32'h4);
        reg_addr = CTRL_ADDR;
        #1;
        chk("R7 control readback", 32'(rdata_f), 32'h20);
        wr(CTRL_ADDR, 8'h01);
        step("R2 request before parking", 4'b1000);
        req = '0;
        repeat (3) tick();
        chk("R7 park on last owner", 32'(gnt_f), 32'h8);
        chk("R7 adaptive park on last owner", 32'(gnt_l), 32'h8);
        wr(CTRL_ADDR, 8'h70);
        tick();
        chk("R7 invalid named master", 32'(gnt_f), 32'h0);
        chk("R7 adaptive invalid named master", 32'(gnt_l), 32'h0);
        step("R2 request after idle", 4'b0100);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule